// File: doc/BRIEF.md
# Paired Block Coder with NRZI Line Serializer

This block turns a stream of parallel characters into a single NRZI line. Each character is cut into a high and a low half, and each half goes through its own block coder. In narrow mode the halves are nibbles and the code is 4B/5B, so a frame is 10 line bits. In wide mode the halves are 5 bits each and the code is 5B/6B, so a frame is 12 line bits. A bypass input sends the character to the shifter uncoded. The two code groups are shifted out high group first, and the NRZI stage turns every 1 into a line transition.

The block runs on the bit clock. It raises `load_strobe` during the last bit of every frame. Its owner presents the next character, the width mode and the bypass setting while the strobe is high. They are captured on that edge, so consecutive frames follow with no gap. If no valid character is offered in a slot, a fixed idle pair fills the frame.

Top module: `pair_line_encoder`

## Requirements
- R1: While `rst_n` is low, `line_out` is 0 and `load_strobe` is 1. The first rising edge after release therefore loads a frame.
- R2: Narrow mode, coded (`wide_mode`=0, `bypass`=0): `char_data[7:4]` and then `char_data[3:0]` are each mapped through this 4B/5B table, with the nibble in hex and the group in hex: 0:1E 1:09 2:14 3:15 4:0A 5:0B 6:0E 7:0F 8:12 9:13 A:16 B:17 C:1A D:1B E:1C F:1D. `char_data[9:8]` has no effect.
- R3: Wide mode, coded (`wide_mode`=1, `bypass`=0): `char_data[9:5]` and then `char_data[4:0]` each become a 6-bit group. The group is the 5 bits followed by one bit chosen so that the group holds an odd number of ones.
- R4: Bypass (`bypass`=1). In narrow mode the 10 frame bits are `char_data[9:0]`. In wide mode the 12 frame bits are `char_data[9:5]`, then 0, then `char_data[4:0]`, then 0.
- R5: A slot with `char_valid`=0 sends the idle pair, whatever `bypass` and `char_data` are: ten ones in narrow mode and twelve ones in wide mode.
- R6: A frame lasts 10 bit clocks in narrow mode and 12 in wide mode. `load_strobe` is high in exactly the last of them.
- R7: The width mode, the bypass setting and the character are sampled only on the edge that ends a strobe cycle. Changing them at any other time does not alter the frame being shifted or its length.
- R8: On each rising edge, `line_out` toggles if the current frame bit is 1 and holds if it is 0.
- R9: Frame bits leave MSB first, high group before low group. The first bit of a frame follows the last bit of the previous frame on the next clock, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 0: 8-bit characters with 4B/5B; 1: 10-bit characters with 5B/6B |
| bypass | input | 1 | 1: skip the block coders |
| char_valid | input | 1 | A character is offered for the next slot |
| char_data | input | 10 | Character to send |
| load_strobe | output | 1 | Last bit of the current frame; inputs are captured on this edge |
| line_out | output | 1 | NRZI serial line |

## Verification
On the strobe edge, three things happen at once: the last bit of the old frame moves the line, the frame counter wraps, and a new frame is captured with a possibly different width mode. The bench provokes this by changing mode, bypass and validity on every strobe, and by changing the mode in the middle of a frame. It judges the result by predicting the line value at every bit and checking the spacing between strobes against the frame length that was captured.

// File: rtl/ple_pkg.sv
package ple_pkg;
  localparam int HALF_W      = 5;
  localparam int NIB_W       = HALF_W - 1;
  localparam int GROUP_W     = HALF_W + 1;
  localparam int FRAME_W     = 2 * GROUP_W;
  localparam int NARROW_BITS = 2 * HALF_W;
  localparam int WIDE_BITS   = FRAME_W;
  localparam int CNT_W       = $clog2(FRAME_W);

  // 4B/5B data group for one nibble
  function automatic logic [HALF_W-1:0] code_4b5b(input logic [NIB_W-1:0] n);
    logic [HALF_W-1:0] g;
    case (n)
      4'h0: g = 5'h1E;
      4'h1: g = 5'h09;
      4'h2: g = 5'h14;
      4'h3: g = 5'h15;
      4'h4: g = 5'h0A;
      4'h5: g = 5'h0B;
      4'h6: g = 5'h0E;
      4'h7: g = 5'h0F;
      4'h8: g = 5'h12;
      4'h9: g = 5'h13;
      4'hA: g = 5'h16;
      4'hB: g = 5'h17;
      4'hC: g = 5'h1A;
      4'hD: g = 5'h1B;
      4'hE: g = 5'h1C;
      default: g = 5'h1D;
    endcase
    return g;
  endfunction

  // extra bit that makes the 6-bit group weight odd
  function automatic logic odd_fill(input logic [HALF_W-1:0] h);
    return ~(^h);
  endfunction

  function automatic logic [CNT_W-1:0] last_index(input logic wide);
    return wide ? CNT_W'(WIDE_BITS - 1) : CNT_W'(NARROW_BITS - 1);
  endfunction
endpackage

// File: rtl/ple_group_coder.sv
module ple_group_coder
  import ple_pkg::*;
(
  input  logic               wide,
  input  logic               bypass,
  input  logic               valid,
  input  logic [HALF_W-1:0]  half,
  output logic [GROUP_W-1:0] group
);
  // group is left-aligned; in narrow mode the LSB is unused
  always_comb begin
    if (!valid) begin
      group = wide ? {GROUP_W{1'b1}} : {{HALF_W{1'b1}}, 1'b0};
    end else if (bypass) begin
      group = {half, 1'b0};
    end else if (wide) begin
      group = {half, odd_fill(half)};
    end else begin
      group = {code_4b5b(half[NIB_W-1:0]), 1'b0};
    end
  end
endmodule

// File: rtl/ple_frame_shifter.sv
module ple_frame_shifter
  import ple_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               load_wide,
  output logic               bit_now,
  output logic               frame_last,
  output logic [CNT_W-1:0]   bit_cnt
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt_last;

  assign bit_now    = shreg[FRAME_W-1];
  assign frame_last = (bit_cnt == cnt_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      cnt_last <= '0;
    end else if (frame_last) begin
      shreg    <= load_word;
      bit_cnt  <= '0;
      cnt_last <= last_index(load_wide);
    end else begin
      shreg    <= {shreg[FRAME_W-2:0], 1'b0};
      bit_cnt  <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ple_nrzi.sv
module ple_nrzi (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  output logic line
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line <= 1'b0;
    else        line <= line ^ bit_in;
  end
endmodule

// File: rtl/pair_line_encoder.sv
module pair_line_encoder
  import ple_pkg::*;
#(
  parameter int CHAR_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              bypass,
  input  logic              char_valid,
  input  logic [CHAR_W-1:0] char_data,
  output logic              load_strobe,
  output logic              line_out
);
  localparam int N_GROUPS = 2;

  logic [GROUP_W-1:0] grp [N_GROUPS];
  logic [FRAME_W-1:0] frame_word;
  logic               bit_now;
  logic               frame_last;
  logic [CNT_W-1:0]   bit_cnt;

  // index 1 is the high half, index 0 the low half
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_half
    logic [HALF_W-1:0] half_in;
    assign half_in = (wide_mode || bypass) ? char_data[g*HALF_W +: HALF_W]
                                           : {1'b0, char_data[g*NIB_W +: NIB_W]};
    ple_group_coder u_coder (
      .wide   (wide_mode),
      .bypass (bypass),
      .valid  (char_valid),
      .half   (half_in),
      .group  (grp[g])
    );
  end

  assign frame_word = wide_mode ? {grp[1], grp[0]}
                                : {grp[1][GROUP_W-1:1], grp[0][GROUP_W-1:1], 2'b00};

  ple_frame_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_word  (frame_word),
    .load_wide  (wide_mode),
    .bit_now    (bit_now),
    .frame_last (frame_last),
    .bit_cnt    (bit_cnt)
  );

  ple_nrzi u_nrzi (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (bit_now),
    .line   (line_out)
  );

  assign load_strobe = frame_last;
endmodule

// File: rtl/pair_line_encoder_chk.sv
module pair_line_encoder_chk
  import ple_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             char_valid,
  input logic             line_out,
  input logic             bit_now,
  input logic             frame_last,
  input logic [CNT_W-1:0] bit_cnt
);
  p_nrzi_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((line_out ^ $past(line_out)) == $past(bit_now)));

  p_frame_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> (bit_cnt == '0));

  p_frame_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_last |=> (bit_cnt == $past(bit_cnt) + 1'b1));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> (int'(bit_cnt) < FRAME_W));

  p_idle_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_last && !char_valid) |=> bit_now);
endmodule

bind pair_line_encoder pair_line_encoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .char_valid (char_valid),
  .line_out   (line_out),
  .bit_now    (bit_now),
  .frame_last (frame_last),
  .bit_cnt    (bit_cnt)
);

// File: tb/test_pair_line_encoder.sv
module test_pair_line_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;
  localparam int N_VEC = 11;
  // packed 4B/5B table, nibble i at bits [i*5 +: 5]
  localparam logic [79:0] NIB_CODES = {5'h1D, 5'h1C, 5'h1B, 5'h1A, 5'h17, 5'h16, 5'h13, 5'h12,
                                       5'h0F, 5'h0E, 5'h0B, 5'h0A, 5'h15, 5'h14, 5'h09, 5'h1E};
  // {wide, bypass, valid, data[9:0], expected frame[11:0] MSB first}
  localparam logic [24:0] VEC [N_VEC] = '{
    {1'b0, 1'b0, 1'b1, 10'h0A5, 12'b101100101100},
    {1'b0, 1'b0, 1'b1, 10'h00F, 12'b111101110100},
    {1'b0, 1'b0, 1'b1, 10'h03C, 12'b101011101000},
    {1'b1, 1'b0, 1'b1, 10'h3FF, 12'b111110111110},
    {1'b1, 1'b0, 1'b1, 10'h000, 12'b000001000001},
    {1'b1, 1'b0, 1'b1, 10'h2A5, 12'b101010001011},
    {1'b0, 1'b1, 1'b1, 10'h155, 12'b010101010100},
    {1'b1, 1'b1, 1'b1, 10'h3E0, 12'b111110000000},
    {1'b0, 1'b0, 1'b0, 10'h123, 12'b111111111100},
    {1'b1, 1'b1, 1'b0, 10'h000, 12'b111111111111},
    {1'b0, 1'b0, 1'b1, 10'h3A5, 12'b101100101100}
  };

  logic clk = 1'b0;
  logic rst_n, wide_mode, bypass, char_valid;
  logic [9:0] char_data;
  logic load_strobe, line_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_line_encoder i_pair_line_encoder (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .bypass(bypass),
    .char_valid(char_valid), .char_data(char_data),
    .load_strobe(load_strobe), .line_out(line_out)
  );

  int checks = 0;
  int errors = 0;

  logic [11:0] drv_word;
  int          drv_len;
  string       drv_tag;
  string       gap_tag = "R6";

  logic        exp_line;
  logic [11:0] exp_sr;
  int          exp_left, gap, prev_len;
  bit          seen_load;
  string       cur_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic par6(input logic [4:0] h);
    return ($countones(h) % 2) == 0;
  endfunction

  function automatic logic [11:0] model_word(input logic m, b, v, input logic [9:0] d);
    if (!v)     return m ? 12'hFFF : 12'hFFC;
    if (b)      return m ? {d[9:5], 1'b0, d[4:0], 1'b0} : {d, 2'b00};
    if (m)      return {d[9:5], par6(d[9:5]), d[4:0], par6(d[4:0])};
    return {NIB_CODES[d[7:4]*5 +: 5], NIB_CODES[d[3:0]*5 +: 5], 2'b00};
  endfunction

  task automatic set_inputs(input logic m, b, v, input logic [9:0] d, input logic [11:0] w);
    wide_mode = m; bypass = b; char_valid = v; char_data = d;
    drv_word = w; drv_len = m ? 12 : 10;
    drv_tag = !v ? "R5" : (b ? "R4" : (m ? "R3" : "R2"));
  endtask

  task automatic put(input logic m, b, v, input logic [9:0] d, input logic [11:0] w);
    do @(negedge clk); while (!load_strobe);
    set_inputs(m, b, v, d, w);
  endtask

  // reference model of the line, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_line = 1'b0; exp_sr = '0; exp_left = 0; gap = 0; seen_load = 1'b0;
    end else begin
      gap++;
      if (exp_left > 0) begin
        exp_line = exp_line ^ exp_sr[11];
        exp_sr = exp_sr << 1;
        exp_left--;
      end
      if (load_strobe) begin
        if (seen_load) chk(gap == prev_len, gap_tag, "frame period", gap, prev_len);
        exp_sr = drv_word; exp_left = drv_len; prev_len = drv_len;
        gap = 0; seen_load = 1'b1; cur_tag = drv_tag;
      end
    end
  end

  // line compared between edges: R8 toggling, R9 order and continuity
  always @(negedge clk) begin
    if (rst_n && seen_load)
      chk(line_out === exp_line, {cur_tag, " R8 R9"}, "line_out", line_out, exp_line);
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R6: actual hung expected strobe");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    set_inputs(1'b0, 1'b0, 1'b0, 10'h000, 12'hFFC);
    repeat (3) @(negedge clk);
    chk(line_out == 1'b0, "R1", "line in reset", line_out, 0);
    chk(load_strobe == 1'b1, "R1", "strobe in reset", load_strobe, 1);
    rst_n = 1'b1;

    // vector table: each entry is one frame, back to back
    for (int i = 0; i < N_VEC; i++)
      put(VEC[i][24], VEC[i][23], VEC[i][22], VEC[i][21:12], VEC[i][11:0]);

    // sweep: every nibble in both positions, every 5-bit half in both positions
    for (int i = 0; i < 16; i++) begin
      logic [9:0] d;
      d = 10'(i * 17 + 256 * (i % 4));
      put(1'b0, 1'b0, 1'b1, d, model_word(1'b0, 1'b0, 1'b1, d));
    end
    for (int i = 0; i < 32; i++) begin
      logic [9:0] d;
      d = {5'(i), ~5'(i)};
      put(1'b1, 1'b0, 1'b1, d, model_word(1'b1, 1'b0, 1'b1, d));
    end

    // R7: change mode, bypass and data in mid-frame; the frame keeps its 10 bits
    put(1'b0, 1'b0, 1'b1, 10'h05A, model_word(1'b0, 1'b0, 1'b1, 10'h05A));
    repeat (4) @(negedge clk);
    wide_mode = 1'b1; bypass = 1'b1; char_data = 10'h3FF;
    gap_tag = "R7";
    put(1'b1, 1'b0, 1'b1, 10'h0C3, model_word(1'b1, 1'b0, 1'b1, 10'h0C3));
    gap_tag = "R6";
    repeat (5) @(negedge clk);
    wide_mode = 1'b0; char_valid = 1'b0;
    gap_tag = "R7";
    put(1'b0, 1'b1, 1'b1, 10'h2D4, model_word(1'b0, 1'b1, 1'b1, 10'h2D4));
    gap_tag = "R6";
    put(1'b1, 1'b1, 1'b0, 10'h3C1, 12'hFFF);
    put(1'b0, 1'b0, 1'b0, 10'h000, 12'hFFC);

    // R1: reset in mid-frame, then restart with a coded frame
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(line_out == 1'b0, "R1", "line after mid-run reset", line_out, 0);
    set_inputs(1'b1, 1'b0, 1'b1, 10'h155, model_word(1'b1, 1'b0, 1'b1, 10'h155));
    @(negedge clk);
    chk(load_strobe == 1'b1, "R1", "strobe after mid-run reset", load_strobe, 1);
    rst_n = 1'b1;
    put(1'b0, 1'b0, 1'b1, 10'h0A5, 12'b101100101100);
    put(1'b0, 1'b0, 1'b0, 10'h000, 12'hFFC);
    put(1'b0, 1'b0, 1'b0, 10'h000, 12'hFFC);
    finish_run();
  end
endmodule